// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a 128-byte memory. A bus master drives a serial clock, an active-low select, a data line into the block and an active-low pause line. The block oversamples all four pins with the system clock and shifts commands, addresses and data in most significant bit first. Its data output changes on falling serial-clock edges, so the master can sample it on rising edges. It decodes six commands: read array, write array, set write enable, clear write enable, read status and write status. It serves sequential reads from a local 128x8 register array and holds the write-enable latch and two protection bits.

Page buffering and the timed programming cycle belong to a neighbouring page-write block. For each data byte of a write frame, this block offers one byte-and-address beat. When the frame closes it sends a one-cycle commit or abort pulse. The neighbour raises a busy input while it programs, and it writes the array through a plain write port.

The byte stream to the neighbour is valid/ready. The serial master cannot be stalled, so `wr_valid` is a single-cycle pulse and is never held. A beat counts as accepted only if `wr_ready` is high in that same cycle. A beat offered while `wr_ready` is low is dropped, and the frame then closes with an abort instead of a commit.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the output enable is low, and a status read returns 0x00. The output enable stays low whenever select is high.
- R2: Input bits are taken on rising serial-clock edges, MSB first. After command 0x03 and an address byte whose low 7 bits give the address, each further byte period returns the stored byte, MSB first, changing on falling edges.
- R3: During a read the address advances by one after each byte and wraps from 0x7F to 0x00.
- R4: Command 0x06 sets the write-enable latch only when select rises directly after its eighth bit. Any further clock edge in the same frame leaves the latch clear.
- R5: Command 0x04 clears the write-enable latch. The latch is also cleared when the busy input falls.
- R6: Command 0x05 returns the status byte {0000, P1, P0, WE, BUSY} (bit 1 = write enable, bit 0 = busy), repeated for as long as clocks continue.
- R7: Command 0x02 with the latch set, then an address byte: each data byte yields one `wr_valid` pulse with its address. The address then advances within its 16-byte page, wrapping from offset 15 to offset 0.
- R8: When select rises on a byte boundary after at least one data byte of an accepted write, `wr_commit` pulses. A rise at any other bit position pulses `wr_abort` instead.
- R9: A data beat offered while `wr_ready` is low is not accepted, and that frame ends with `wr_abort` and no `wr_commit`.
- R10: A write or status write is refused, with no beats, when the latch is clear or busy is high at the command byte.
- R11: While busy is high an array read is refused and the output enable stays low. A status read still works and shows bit 0 set.
- R12: While the pause line is low all shift and decode state is frozen, clock edges are ignored and the output is disabled. On release the transfer resumes at the same bit.
- R13: Any other command value is ignored until select rises: no output, no beats, and no change of status.
- R14: Command 0x01 with the latch set loads P1/P0 from bits 3:2 of its data byte and clears the latch. Without the latch it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master (idles low) |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_si | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Active-low pause |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for spi_so (low = high impedance) |
| wr_valid | output | 1 | One-cycle data beat to the page-write block |
| wr_ready | input | 1 | Page-write block accepts a beat this cycle |
| wr_addr | output | 7 | Array address of the beat |
| wr_data | output | 8 | Data of the beat |
| wr_commit | output | 1 | Pulse: write frame closed correctly |
| wr_abort | output | 1 | Pulse: write frame closed badly or lost a beat |
| wc_busy | input | 1 | Programming cycle in progress |
| mem_we | input | 1 | Array write strobe from the page-write block |
| mem_addr | input | 7 | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
A wrong bit counter or phase shows at once as shifted or rotated read bytes, or as a status byte that appears one bit off. A read pointer that skips or fails to wrap shows on the first byte past the faulty step. A latch that is set too eagerly is exposed when status is read after a frame holding extra clocks, and beats then appear that should not. A hold that does not freeze corrupts the byte straddling the pause. The beat addresses show the page wrap on the seventeenth byte, or at the first offset past 15.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] CMD_STWR = 8'h01;
  localparam logic [7:0] CMD_WR   = 8'h02;
  localparam logic [7:0] CMD_RD   = 8'h03;
  localparam logic [7:0] CMD_WDIS = 8'h04;
  localparam logic [7:0] CMD_STRD = 8'h05;
  localparam logic [7:0] CMD_WEN  = 8'h06;

  typedef enum logic [2:0] {
    PH_CMD,    // collecting the command byte
    PH_ADDR,   // collecting the address byte
    PH_RDATA,  // streaming array bytes out
    PH_WDATA,  // collecting bytes for the page-write block
    PH_STAT,   // streaming the status byte out
    PH_STWR,   // collecting the status write byte
    PH_WEN,    // write-enable byte done, waiting for select to rise
    PH_SKIP    // frame ignored until select rises
  } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic cs_act,
  output logic si_s,
  output logic hold_act
);
  localparam int NPIN = 4;
  // pin order {hold_n, si, cs_n, sck}, idle levels
  localparam logic [NPIN-1:0] IDLE = 4'b1010;

  logic [NPIN-1:0] stage [STAGES];
  logic [1:0]      last;
  logic [NPIN-1:0] cur;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= IDLE;
          else        stage[g] <= {hold_n, si, cs_n, sck};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= IDLE;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign cur = stage[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IDLE[1:0];
    else        last <= cur[1:0];
  end

  assign sck_rise = cur[0] & ~last[0];
  assign sck_fall = ~cur[0] & last[0];
  assign cs_rise  = cur[1] & ~last[1];
  assign cs_fall  = ~cur[1] & last[1];
  assign cs_act   = ~cur[1];
  assign si_s     = cur[2];
  assign hold_act = ~cur[3];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_mem_pkg::*;
#(
  parameter int AW         = 7,
  parameter int PAGE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          cs_act,
  input  logic          si_s,
  input  logic          hold_act,
  input  logic          busy,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          so,
  output logic          so_oe,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic          wr_abort
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [PW-1:0] PSTEP = 1;
  localparam logic [AW-1:0] ASTEP = 1;

  phase_e        phase;
  logic [2:0]    bit_cnt;
  logic [6:0]    shreg;
  logic [AW-1:0] ptr;
  logic          is_rd;
  logic          wel;
  logic [1:0]    bp;
  logic          busy_q;
  logic          got_byte;
  logic          lost;

  logic       active, rise, fall, byte_done;
  logic [7:0] byte_in;
  logic [7:0] status;

  assign active    = cs_act & ~hold_act;
  assign rise      = sck_rise & active;
  assign fall      = sck_fall & active;
  assign byte_in   = {shreg, si_s};
  assign byte_done = rise && (bit_cnt == 3'd7);
  assign status    = {4'b0000, bp, wel, busy};
  assign rd_addr   = ptr;
  assign so_oe     = active && (phase == PH_RDATA || phase == PH_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      shreg     <= '0;
      ptr       <= '0;
      is_rd     <= 1'b0;
      wel       <= 1'b0;
      bp        <= '0;
      busy_q    <= 1'b0;
      got_byte  <= 1'b0;
      lost      <= 1'b0;
      so        <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
      wr_abort  <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      wr_abort  <= 1'b0;
      busy_q    <= busy;
      if (busy_q && !busy) wel <= 1'b0;
      if (wr_valid && !wr_ready) lost <= 1'b1;

      if (cs_rise || cs_fall) begin
        if (cs_rise && phase == PH_WEN) wel <= 1'b1;
        if (cs_rise && phase == PH_WDATA) begin
          if (bit_cnt == 3'd0 && got_byte && !lost && !(wr_valid && !wr_ready))
            wr_commit <= 1'b1;
          else
            wr_abort <= 1'b1;
        end
        phase    <= PH_CMD;
        bit_cnt  <= '0;
        got_byte <= 1'b0;
        lost     <= 1'b0;
      end else if (rise) begin
        shreg   <= byte_in[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (phase == PH_WEN) begin
          phase <= PH_SKIP;
        end else if (byte_done) begin
          case (phase)
            PH_CMD: begin
              case (byte_in)
                CMD_RD: begin
                  phase <= PH_ADDR;
                  is_rd <= 1'b1;
                end
                CMD_WR: begin
                  is_rd <= 1'b0;
                  phase <= (wel && !busy) ? PH_ADDR : PH_SKIP;
                end
                CMD_WEN:  phase <= PH_WEN;
                CMD_WDIS: begin
                  wel   <= 1'b0;
                  phase <= PH_SKIP;
                end
                CMD_STRD: phase <= PH_STAT;
                CMD_STWR: phase <= (wel && !busy) ? PH_STWR : PH_SKIP;
                default:  phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              ptr <= byte_in[AW-1:0];
              if (is_rd) phase <= busy ? PH_SKIP : PH_RDATA;
              else       phase <= PH_WDATA;
            end
            PH_RDATA: ptr <= ptr + ASTEP;
            PH_WDATA: begin
              wr_valid <= 1'b1;
              wr_addr  <= ptr;
              wr_data  <= byte_in;
              got_byte <= 1'b1;
              ptr      <= {ptr[AW-1:PW], ptr[PW-1:0] + PSTEP};
            end
            PH_STWR: begin
              bp    <= byte_in[3:2];
              wel   <= 1'b0;
              phase <= PH_SKIP;
            end
            default: ;
          endcase
        end
      end else if (fall) begin
        if (phase == PH_RDATA)     so <= rd_data[~bit_cnt];
        else if (phase == PH_STAT) so <= status[~bit_cnt];
      end
    end
  end

  // R4: the latch only rises in the cycle after select was seen rising
  assert_wel_on_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  // R3: read pointer steps by one (modulo array size) at each completed byte
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_RDATA) |=> (ptr == $past(ptr) + ASTEP));

  // R7: each beat is a single-cycle pulse
  assert_beat_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R10: beats only appear while the latch is set
  assert_beat_needs_wel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wel);

  // R8: frame-close pulses follow a select rise
  assert_close_after_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit || wr_abort) |-> $past(cs_rise));

  // R12: frozen while paused
  assert_hold_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_rise && !cs_fall) |=> ($stable(bit_cnt) && $stable(phase) && $stable(ptr)));

  // R11: no array streaming while the programming cycle runs
  assert_no_read_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RDATA) |-> !busy);
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int AW          = 7,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_si,
  input  logic          spi_hold_n,
  output logic          spi_so,
  output logic          spi_so_oe,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic          wr_abort,
  input  logic          wc_busy,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_wdata
);
  logic          sck_rise, sck_fall, cs_rise, cs_fall, cs_act, si_s, hold_act;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .si       (spi_si),
    .hold_n   (spi_hold_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .cs_act   (cs_act),
    .si_s     (si_s),
    .hold_act (hold_act)
  );

  spi_mem_array #(.AW(AW), .DW(8)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  spi_cmd_fsm #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .cs_act    (cs_act),
    .si_s      (si_s),
    .hold_act  (hold_act),
    .busy      (wc_busy),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .so        (spi_so),
    .so_oe     (spi_so_oe),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_commit (wr_commit),
    .wr_abort  (wr_abort)
  );

  // R1: no drive while select is high
  assert_quiet_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_so_oe);
endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int MAX_CYC    = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  logic wr_valid, wr_commit, wr_abort;
  logic wr_ready = 1'b1;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic busy = 1'b0, mem_we = 1'b0;
  logic [6:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;

  int checks = 0, errors = 0;
  logic [7:0] exp_mem [128];
  logic [1:0] exp_bp = 2'b00;
  logic [6:0] cap_a [64];
  logic [7:0] cap_d [64];
  int ncap = 0, ncommit = 0, nabort = 0;
  bit oe_seen = 1'b0;
  logic [7:0] wbuf [32];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_slave i_spi_mem_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_abort(wr_abort), .wc_busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (wr_valid && wr_ready && ncap < 64) begin
      cap_a[ncap] = wr_addr;
      cap_d[ncap] = wr_data;
      ncap++;
    end
    if (wr_commit) ncommit++;
    if (wr_abort)  nabort++;
    if (so_oe)     oe_seen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  function automatic logic [7:0] stat_exp(input bit wel, input bit wip);
    return {4'b0000, exp_bp, wel, wip};
  endfunction

  function automatic logic [6:0] page_addr(input logic [6:0] a, input int k);
    return {a[6:4], 4'(int'(a[3:0]) + k)};
  endfunction

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = so;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer_hold(input logic [7:0] tx, input int at, output logic [7:0] rx, output bit oe_in_hold);
    oe_in_hold = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      repeat (HALF) @(negedge clk);
      if (b == at) begin
        hold_n = 1'b0;
        repeat (8) @(negedge clk);
        if (so_oe) oe_in_hold = 1'b1;
        sck = 1'b1;
        repeat (6) @(negedge clk);
        if (so_oe) oe_in_hold = 1'b1;
        sck = 1'b0;
        repeat (6) @(negedge clk);
        hold_n = 1'b1;
        repeat (8) @(negedge clk);
      end
      rx[b] = so;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic send_bits(input logic [7:0] tx, input int n);
    for (int b = 7; b > 7 - n; b--) begin
      si = tx[b];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic one_cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xfer(op, r); cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); xfer(8'h05, r); xfer(8'h00, s); cs_hi();
  endtask

  task automatic direct_write(input logic [6:0] a, input logic [7:0] d);
    mem_addr = a; mem_wdata = d; mem_we = 1'b1;
    @(negedge clk);
    mem_we = 1'b0;
    exp_mem[a] = d;
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string req);
    logic [7:0] r;
    logic [6:0] idx;
    cs_lo(); xfer(8'h03, r); xfer({1'b0, a}, r);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      idx = 7'(int'(a) + i);
      check(r === exp_mem[idx], req, r, exp_mem[idx]);
    end
    cs_hi();
  endtask

  task automatic do_write(input logic [6:0] a, input int n);
    logic [7:0] r;
    cs_lo(); xfer(8'h02, r); xfer({1'b0, a}, r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], r);
    cs_hi();
  endtask

  task automatic check_beats(input logic [6:0] a, input int n, input string req);
    check(ncap == n, req, ncap, n);
    for (int i = 0; i < n && i < ncap; i++) begin
      check(cap_a[i] == page_addr(a, i), req, cap_a[i], page_addr(a, i));
      check(cap_d[i] == wbuf[i], req, cap_d[i], wbuf[i]);
    end
  endtask

  task automatic program_page(input logic [6:0] a, input int n);
    busy = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) direct_write(page_addr(a, i), wbuf[i]);
  endtask

  task automatic end_busy();
    busy = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] s, r, s2;
    logic [6:0] a;
    int n, c0, b0;
    bit oh;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check(so_oe == 1'b0, "R1 oe after reset", so_oe, 0);
    rd_status(s);
    check(s == 8'h00, "R1 status after reset", s, 0);
    do_read(7'h05, 1, "R1 array cleared");

    for (int i = 0; i < 128; i++) direct_write(7'(i), 8'(i * 37 + 5));

    // R2: plain reads
    do_read(7'h10, 3, "R2 read");
    do_read(7'h00, 2, "R2 read low");
    // R3: wrap at top address
    do_read(7'h7D, 5, "R3 wrap");

    // R4 and R6: enable latch, status repeats
    one_cmd(8'h06);
    cs_lo(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, s2); cs_hi();
    check(s == stat_exp(1, 0), "R4 latch set", s, stat_exp(1, 0));
    check(s2 == s, "R6 status repeats", s2, s);

    // R5: disable clears
    one_cmd(8'h04);
    rd_status(s);
    check(s == stat_exp(0, 0), "R5 disable clears", s, stat_exp(0, 0));

    // R4: extra clocks after enable in same frame
    ncap = 0;
    cs_lo(); xfer(8'h06, r); xfer(8'h02, r); xfer(8'h10, r); xfer(8'hAA, r); cs_hi();
    rd_status(s);
    check(s == stat_exp(0, 0), "R4 no latch with extra clocks", s, stat_exp(0, 0));
    check(ncap == 0, "R10 no beats without latch", ncap, 0);

    // R10: write with latch clear
    wbuf[0] = 8'h5A;
    do_write(7'h30, 1);
    check(ncap == 0, "R10 write refused", ncap, 0);

    // R7, R8: page write wrapping inside the page
    one_cmd(8'h06);
    ncap = 0; c0 = ncommit; b0 = nabort;
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
    do_write(7'h2E, 4);
    check_beats(7'h2E, 4, "R7 beats");
    check(ncommit == c0 + 1, "R8 commit", ncommit, c0 + 1);
    check(nabort == b0, "R8 no abort", nabort, b0);

    // R11: during busy
    program_page(7'h2E, 4);
    rd_status(s);
    check(s == stat_exp(1, 1), "R11 status while busy", s, stat_exp(1, 1));
    oe_seen = 1'b0;
    cs_lo(); xfer(8'h03, r); xfer(8'h20, r); xfer(8'h00, r); cs_hi();
    check(oe_seen == 1'b0, "R11 read refused", oe_seen, 0);
    ncap = 0;
    do_write(7'h50, 1);
    check(ncap == 0, "R10 write refused while busy", ncap, 0);
    end_busy();
    rd_status(s);
    check(s == stat_exp(0, 0), "R5 latch cleared at end of busy", s, stat_exp(0, 0));
    do_read(7'h2C, 6, "R7 page contents");

    // R8: select rising mid byte
    one_cmd(8'h06);
    ncap = 0; c0 = ncommit; b0 = nabort;
    cs_lo(); xfer(8'h02, r); xfer(8'h40, r); xfer(8'h11, r); send_bits(8'h22, 3); cs_hi();
    check(nabort == b0 + 1, "R8 abort mid byte", nabort, b0 + 1);
    check(ncommit == c0, "R8 no commit mid byte", ncommit, c0);

    // R9: back-pressure
    wr_ready = 1'b0;
    ncap = 0; c0 = ncommit; b0 = nabort;
    wbuf[0] = 8'h33; wbuf[1] = 8'h44;
    do_write(7'h48, 2);
    check(ncap == 0, "R9 no accepted beats", ncap, 0);
    check(nabort == b0 + 1, "R9 abort", nabort, b0 + 1);
    check(ncommit == c0, "R9 no commit", ncommit, c0);
    wr_ready = 1'b1;
    one_cmd(8'h04);

    // R12: pause in address byte and in data byte
    oh = 1'b0;
    cs_lo(); xfer(8'h03, r); xfer_hold(8'h33, 3, r, oh);
    xfer_hold(8'h00, 4, r, oh);
    check(r == exp_mem[7'h33], "R12 byte across pause", r, exp_mem[7'h33]);
    check(oh == 1'b0, "R12 output off in pause", oh, 0);
    xfer(8'h00, r);
    check(r == exp_mem[7'h34], "R12 next byte", r, exp_mem[7'h34]);
    cs_hi();

    // R13: unknown command
    oe_seen = 1'b0; ncap = 0;
    cs_lo(); xfer(8'hA5, r); xfer(8'h06, r); xfer(8'h03, r); cs_hi();
    check(oe_seen == 1'b0, "R13 no output", oe_seen, 0);
    rd_status(s);
    check(s == stat_exp(0, 0), "R13 status unchanged", s, stat_exp(0, 0));

    // R14: status write
    one_cmd(8'h06);
    cs_lo(); xfer(8'h01, r); xfer(8'hFC, r); cs_hi();
    exp_bp = 2'b11;
    rd_status(s);
    check(s == stat_exp(0, 0), "R14 protect bits", s, stat_exp(0, 0));
    cs_lo(); xfer(8'h01, r); xfer(8'h00, r); cs_hi();
    rd_status(s);
    check(s == stat_exp(0, 0), "R14 refused without latch", s, stat_exp(0, 0));

    // random page writes then reads (R7, R2, R3)
    for (int t = 0; t < 6; t++) begin
      a = 7'($urandom % 128);
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      one_cmd(8'h06);
      ncap = 0; c0 = ncommit;
      do_write(a, n);
      check_beats(a, n, "R7 random beats");
      check(ncommit == c0 + 1, "R8 random commit", ncommit, c0 + 1);
      program_page(a, n);
      end_busy();
    end
    for (int t = 0; t < 10; t++) begin
      a = 7'($urandom % 128);
      n = 1 + int'($urandom % 5);
      do_read(a, n, "R3 random read");
    end
    do_read(7'h7F, 3, "R3 wrap from top");

    finish_run();
  end
endmodule